// File: doc/BRIEF.md
# Latency Port Slot Lending and Repayment

This unit sits behind a round-robin grant scheduler. The scheduler names a token holder each cycle. The unit may hand that cycle's slot to port 0, the one latency-sensitive port, instead of the holder. Each loan is logged by lender ID in a FIFO ledger. The scheduler's token is never touched, so the base rotation carries on as if no loan had been made.

Loans are paid back from spare bandwidth. Each cycle the scheduler supplies a fractional residual-bandwidth figure. While the ledger holds entries, that figure is summed into a saturating fixed-point repayment accumulator. Each time the accumulator holds one whole slot, the oldest lender is removed from the ledger. That lender's debit counter is raised by one. The scheduler later spends debit units through a per-port consume strobe. A ledger-empty flag tells the credit logic when residual bandwidth may go to the other ports.

Top module: `cbr_unit`

## Requirements
- R1: When `hp_empty` is low, `tok_id` is not 0 and the ledger holds fewer than DEPTH entries, `grant_id` is 0 in that same cycle. `tok_id` is appended to the ledger at the next clock edge.
- R2: In every other case `grant_id` equals `tok_id` and nothing is appended. This covers port 0 holding the token, port 0 having no request, and a full ledger.
- R3: The ledger holds DEPTH entries (default 16). Lenders are repaid strictly in the order they lent.
- R4: `resid` is a fraction in units of 2^-FRAC (FRAC = 8 by default, so a value of 256 is one whole slot). In every cycle where the ledger is not empty at the start of the cycle, `resid` is added to the repayment accumulator. While the ledger is empty, the accumulator holds its value.
- R5: When the ledger is not empty and the accumulator is at least one whole slot at the start of a cycle, the oldest lender is removed at the next edge. That lender's debit counter rises by one, and one whole slot is subtracted from the accumulator after the same cycle's `resid` is added.
- R6: The accumulator has FRAC fractional bits and ACC_INT integer bits, with a default maximum of 2047/256. It clamps at that maximum instead of wrapping.
- R7: An append and a removal in the same cycle leave the ledger occupancy unchanged.
- R8: Debit counter p (bits p*DW upward in `debit_cnt`) falls only on `debit_use[p]`, and only when it is non-zero. A rise and a fall in the same cycle leave it unchanged. It clamps at its maximum.
- R9: After reset the ledger is empty, the accumulator is 0 and all debit counters are 0. `debt_empty` is high exactly when the ledger holds no entries.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tok_id | input | IDW | Port currently holding the round-robin token |
| hp_empty | input | 1 | Port 0 request queue is empty |
| resid | input | FRAC+1 | Residual bandwidth this cycle, units of 2^-FRAC |
| debit_use | input | NPORTS | Per-port strobe: scheduler spent one debit unit |
| grant_id | output | IDW | Port granted this cycle |
| debit_cnt | output | NPORTS*DW | Packed per-port debit counters |
| debt_empty | output | 1 | Ledger holds no entries |

## Verification
The checker tests several properties on every cycle:
- the grant choice against the borrow condition;
- ledger occupancy against the push and pop strobes;
- the fact that a removal only happens when the accumulator holds a whole slot;
- the rule that the accumulator never falls without a removal;
- debit counters that stay still when neither the strobe nor a repayment touches them.

Only the bench scenarios can show the things that need history. These are repayment in lending order, the exact removal cadence for a given fractional rate, and the recovery after the accumulator clamps.

// File: rtl/cbr_pkg.sv
package cbr_pkg;

  // Next accumulator value: add, optionally take one whole slot, clamp at lim.
  function automatic int unsigned acc_update(int unsigned acc, int unsigned add,
                                             bit take, int unsigned one,
                                             int unsigned lim);
    int unsigned s;
    s = acc + add;
    if (take) s = s - one;
    if (s > lim) s = lim;
    return s;
  endfunction

  // Up/down counter step with clamp; simultaneous up and down cancel.
  function automatic int unsigned cnt_update(int unsigned c, bit up, bit dn,
                                             int unsigned lim);
    if (up && !dn) return (c >= lim) ? lim : c + 1;
    if (dn && !up) return c - 1;
    return c;
  endfunction

endpackage

// File: rtl/cbr_lender_fifo.sv
module cbr_lender_fifo #(
  parameter int DEPTH = 16,
  parameter int IDW   = 2,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           push,
  input  logic [IDW-1:0] push_id,
  input  logic           pop,
  output logic [IDW-1:0] head_id,
  output logic [CW-1:0]  count,
  output logic           full,
  output logic           empty
);
  logic [IDW-1:0] mem [DEPTH];
  logic [PW-1:0]  wp, rp;

  function automatic logic [PW-1:0] bump(logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign head_id = mem[rp];

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= push_id;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (push) wp <= bump(wp);
      if (pop)  rp <= bump(rp);
      if (push && !pop)      count <= count + 1'b1;
      else if (pop && !push) count <= count - 1'b1;
    end
  end
endmodule

// File: rtl/cbr_repay_acc.sv
module cbr_repay_acc #(
  parameter int FRAC    = 8,
  parameter int ACC_INT = 3,
  localparam int RES_W  = FRAC + 1,
  localparam int ACC_W  = FRAC + ACC_INT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic [RES_W-1:0] resid,
  output logic             take,
  output logic [ACC_W-1:0] acc
);
  import cbr_pkg::*;
  localparam int unsigned ONE = 1 << FRAC;
  localparam int unsigned LIM = (1 << ACC_W) - 1;

  logic [ACC_W-1:0] acc_d;

  assign take = active && (32'(acc) >= ONE);

  always_comb begin
    acc_d = acc;
    if (active) acc_d = ACC_W'(acc_update(32'(acc), 32'(resid), take, ONE, LIM));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc <= '0;
    else        acc <= acc_d;
  end
endmodule

// File: rtl/cbr_debit_bank.sv
module cbr_debit_bank #(
  parameter int NPORTS = 4,
  parameter int DW     = 8,
  localparam int IDW   = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 inc_en,
  input  logic [IDW-1:0]       inc_id,
  input  logic [NPORTS-1:0]    use_vec,
  output logic [NPORTS*DW-1:0] cnt_flat
);
  import cbr_pkg::*;
  localparam int unsigned LIM = (1 << DW) - 1;

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    logic [DW-1:0] cnt;
    logic          up, dn;
    assign up = inc_en && (inc_id == IDW'(p));
    assign dn = use_vec[p] && (cnt != '0);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt <= '0;
      else        cnt <= DW'(cnt_update(32'(cnt), up, dn, LIM));
    end
    assign cnt_flat[p*DW +: DW] = cnt;
  end
endmodule

// File: rtl/cbr_unit.sv
module cbr_unit #(
  parameter int NPORTS  = 4,
  parameter int DEPTH   = 16,
  parameter int FRAC    = 8,
  parameter int ACC_INT = 3,
  parameter int DW      = 8,
  localparam int IDW    = (NPORTS > 1) ? $clog2(NPORTS) : 1,
  localparam int CW     = $clog2(DEPTH + 1),
  localparam int RES_W  = FRAC + 1,
  localparam int ACC_W  = FRAC + ACC_INT
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [IDW-1:0]       tok_id,
  input  logic                 hp_empty,
  input  logic [RES_W-1:0]     resid,
  input  logic [NPORTS-1:0]    debit_use,
  output logic [IDW-1:0]       grant_id,
  output logic [NPORTS*DW-1:0] debit_cnt,
  output logic                 debt_empty
);
  logic             push_w, pop_w, full_w;
  logic [IDW-1:0]   head_w;
  logic [CW-1:0]    fill_w;
  logic [ACC_W-1:0] acc_w;

  // Borrow: port 0 waiting, someone else holds the token, ledger has room.
  assign push_w   = !hp_empty && (tok_id != '0) && !full_w;
  assign grant_id = push_w ? '0 : tok_id;

  cbr_lender_fifo #(.DEPTH(DEPTH), .IDW(IDW)) ledger_i (
    .clk(clk), .rst_n(rst_n), .push(push_w), .push_id(tok_id), .pop(pop_w),
    .head_id(head_w), .count(fill_w), .full(full_w), .empty(debt_empty)
  );

  cbr_repay_acc #(.FRAC(FRAC), .ACC_INT(ACC_INT)) repay_i (
    .clk(clk), .rst_n(rst_n), .active(!debt_empty), .resid(resid),
    .take(pop_w), .acc(acc_w)
  );

  cbr_debit_bank #(.NPORTS(NPORTS), .DW(DW)) debit_i (
    .clk(clk), .rst_n(rst_n), .inc_en(pop_w), .inc_id(head_w),
    .use_vec(debit_use), .cnt_flat(debit_cnt)
  );
endmodule

// File: rtl/cbr_unit_chk.sv
module cbr_unit_chk #(
  parameter int NPORTS  = 4,
  parameter int DEPTH   = 16,
  parameter int FRAC    = 8,
  parameter int ACC_INT = 3,
  parameter int DW      = 8,
  localparam int IDW    = (NPORTS > 1) ? $clog2(NPORTS) : 1,
  localparam int CW     = $clog2(DEPTH + 1),
  localparam int ACC_W  = FRAC + ACC_INT
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [IDW-1:0]       tok_id,
  input logic                 hp_empty,
  input logic [NPORTS-1:0]    debit_use,
  input logic [IDW-1:0]       grant_id,
  input logic [NPORTS*DW-1:0] debit_cnt,
  input logic                 debt_empty,
  input logic                 push_w,
  input logic                 pop_w,
  input logic                 full_w,
  input logic [IDW-1:0]       head_w,
  input logic [CW-1:0]        fill_w,
  input logic [ACC_W-1:0]     acc_w
);
  localparam int unsigned ONE = 1 << FRAC;

  // R1
  borrow_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hp_empty && tok_id != '0 && !full_w) |-> (grant_id == '0 && push_w));

  // R2
  pass_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hp_empty || tok_id == '0 || full_w) |-> (grant_id == tok_id && !push_w));

  // R3
  ledger_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_w <= CW'(DEPTH)) && (full_w == (fill_w == CW'(DEPTH))));

  // R5
  pop_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop_w |-> (!debt_empty && 32'(acc_w) >= ONE));

  // R6
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!debt_empty && !pop_w) |=> (acc_w >= $past(acc_w)));

  // R7
  push_pop_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_w && pop_w) |=> (fill_w == $past(fill_w)));

  // R9
  empty_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    debt_empty == (fill_w == '0));

  for (genvar p = 0; p < NPORTS; p++) begin : g_chk
    // R8
    debit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((!debit_use[p] || debit_cnt[p*DW +: DW] == '0) && !(pop_w && head_w == IDW'(p)))
      |=> (debit_cnt[p*DW +: DW] == $past(debit_cnt[p*DW +: DW])));
  end
endmodule

bind cbr_unit cbr_unit_chk #(
  .NPORTS(NPORTS), .DEPTH(DEPTH), .FRAC(FRAC), .ACC_INT(ACC_INT), .DW(DW)
) chk_i (
  .clk(clk), .rst_n(rst_n), .tok_id(tok_id), .hp_empty(hp_empty),
  .debit_use(debit_use), .grant_id(grant_id), .debit_cnt(debit_cnt),
  .debt_empty(debt_empty), .push_w(push_w), .pop_w(pop_w), .full_w(full_w),
  .head_w(head_w), .fill_w(fill_w), .acc_w(acc_w)
);

// File: tb/cbr_unit_tb.sv
module cbr_unit_tb_top;
  localparam int NPORTS = 4;
  localparam int DEPTH  = 16;
  localparam int FRAC   = 8;
  localparam int ACC_INT = 3;
  localparam int DW     = 8;
  localparam int IDW    = 2;
  localparam int ONE    = 1 << FRAC;
  localparam int AMAX   = (1 << (FRAC + ACC_INT)) - 1;
  localparam int DMAX   = (1 << DW) - 1;

  logic                 clk = 0;
  logic                 rst_n = 0;
  logic [IDW-1:0]       tok_id = '0;
  logic                 hp_empty = 1;
  logic [FRAC:0]        resid = '0;
  logic [NPORTS-1:0]    debit_use = '0;
  logic [IDW-1:0]       grant_id;
  logic [NPORTS*DW-1:0] debit_cnt;
  logic                 debt_empty;

  always #10 clk = ~clk;

  cbr_unit #(.NPORTS(NPORTS), .DEPTH(DEPTH), .FRAC(FRAC), .ACC_INT(ACC_INT), .DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .tok_id(tok_id), .hp_empty(hp_empty), .resid(resid),
    .debit_use(debit_use), .grant_id(grant_id), .debit_cnt(debit_cnt),
    .debt_empty(debt_empty)
  );

  typedef struct { int g; bit e; int d [NPORTS]; } exp_t;
  exp_t exp_q [$];

  int checks = 0, errors = 0;
  int mq [$];
  int macc = 0;
  int mdeb [NPORTS];

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Driver: drive one cycle, queue the expected outputs, advance the model.
  task automatic cyc(int tok, bit hpe, int d, logic [NPORTS-1:0] use_v);
    exp_t e;
    bit borrow, pop;
    int head, s;
    @(negedge clk);
    tok_id = IDW'(tok); hp_empty = hpe; resid = (FRAC+1)'(d); debit_use = use_v;
    borrow = !hpe && tok != 0 && mq.size() < DEPTH;
    e.g = borrow ? 0 : tok;
    e.e = (mq.size() == 0);
    for (int p = 0; p < NPORTS; p++) e.d[p] = mdeb[p];
    exp_q.push_back(e);
    pop = mq.size() > 0 && macc >= ONE;
    head = (mq.size() > 0) ? mq[0] : -1;
    if (mq.size() > 0) begin
      s = macc + d - (pop ? ONE : 0);
      macc = (s > AMAX) ? AMAX : s;
    end
    if (pop) void'(mq.pop_front());
    if (borrow) mq.push_back(tok);
    for (int p = 0; p < NPORTS; p++) begin
      bit up, dn;
      up = pop && head == p;
      dn = use_v[p] && mdeb[p] != 0;
      if (up && !dn) mdeb[p] = (mdeb[p] >= DMAX) ? DMAX : mdeb[p] + 1;
      else if (dn && !up) mdeb[p] = mdeb[p] - 1;
    end
  endtask

  // Monitor: compare design outputs against queued expectations.
  initial begin
    forever begin
      @(negedge clk);
      #5;
      while (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        chk(int'(grant_id) == e.g, "R1 R2", "grant_id", int'(grant_id), e.g);
        chk(debt_empty == e.e, "R3 R7 R9", "debt_empty", int'(debt_empty), int'(e.e));
        for (int p = 0; p < NPORTS; p++)
          chk(int'(debit_cnt[p*DW +: DW]) == e.d[p], "R4 R5 R6 R8", "debit_cnt",
              int'(debit_cnt[p*DW +: DW]), e.d[p]);
      end
    end
  end

  initial begin
    #(20 * 200000);
    errors++; checks++;
    $display("FAIL R9 watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int p = 0; p < NPORTS; p++) mdeb[p] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #5;
    // R9 reset state
    chk(debt_empty == 1'b1, "R9", "reset debt_empty", int'(debt_empty), 1);
    chk(debit_cnt == '0, "R9", "reset debit_cnt", int'(debit_cnt), 0);
    // R2: holder is port 0, and port 0 idle
    cyc(0, 0, 0, '0);
    cyc(2, 1, 0, '0);
    cyc(3, 1, 100, '0);
    // R1, R3: fill ledger, then blocked when full
    for (int i = 0; i < 18; i++) cyc(1 + (i % 3), 0, 0, '0);
    // R4, R5: quarter-slot rate, repaid in lending order
    for (int i = 0; i < 24; i++) cyc(1, 1, 64, '0);
    // R8: consume strobes, some colliding with repayments
    for (int i = 0; i < 16; i++) cyc(2, 1, 128, 4'b1110);
    // R7: push and pop in the same cycle
    for (int i = 0; i < 12; i++) cyc(3, 0, 256, '0);
    // R6: clamp the accumulator, then drain at zero rate
    for (int i = 0; i < 20; i++) cyc(1 + (i % 3), 0, 511, '0);
    for (int i = 0; i < 20; i++) cyc(2, 1, 0, '0);
    // Mixed traffic
    for (int i = 0; i < 400; i++)
      cyc(int'($urandom_range(0, 3)), bit'($urandom_range(0, 1)),
          int'($urandom_range(0, 300)), NPORTS'($urandom_range(0, 15)));
    // Drain
    for (int i = 0; i < 40; i++) cyc(1, 1, 256, 4'b1111);
    repeat (2) @(negedge clk);
    #8;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule